// File: doc/BRIEF.md
# Grouped Event Combiner with Dual Masking

This block collects a wide vector of single-cycle system event pulses and holds each one as a sticky pending flag. The flags are split into groups of equal width, 4 groups of 32 by default, so event number n is held in group n/32 at bit n%32. Software reaches the flags through a small word-addressed register bus. It can set flags, clear them with write-one-per-bit semantics, and give each group two independent masks.

The first mask plane feeds one interrupt line per group. Each line is a registered level that is high while any unmasked flag of that group is pending. The second mask plane feeds one exception line, the OR of every group's exception-unmasked flags. Each plane has a read-only masked view per group. A service routine therefore finds the lowest set bit in its view, clears that bit, and repeats until the view reads zero.

A separate software event-assert register turns one bus write into a one-cycle request pulse that carries the written value.

Top module: `evt_combiner`

## Requirements
- R1: A one-cycle high on event input bit n sets the pending flag at bit n%32 of group n/32 on the next clock edge. The flag stays set until software clears it.
- R2: A write to the set register of a group (bank 1) sets every flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R3: A write to the clear register of a group (bank 2) clears every flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged. If an event pulse reaches the same bit in the same cycle, the flag ends up set.
- R4: After reset all flags are 0, all bits of both mask planes are 1, and the interrupt lines, exception line and assert pulse are low.
- R5: The interrupt mask (bank 3) and exception mask (bank 5) of each group can be read and written. A mask bit of 1 blocks its flag and a mask bit of 0 passes it.
- R6: The interrupt view (bank 4) reads flag AND NOT interrupt-mask for the group. The exception view (bank 6) reads flag AND NOT exception-mask.
- R7: Interrupt output bit g is a registered level. It equals the OR of group g's interrupt view and updates on the same clock edge as the flag or mask change that causes it.
- R8: The exception output is the OR of all bits of all exception views, and it updates on the same edge as the flags and masks.
- R9: A write to the assert register (bank 7, group field 0) produces a one-cycle valid pulse on the next edge, with the written word on the assert data output.
- R10: Word address bits [5:3] select the bank and bits [2:0] select the group. Writes to the flag bank (0) and to the view banks (4, 6) change nothing. Reads of the set, clear and assert banks return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 128 | Event pulses, bit n goes to group n/32 |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address: bank in [5:3], group in [2:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| grp_irq_o | output | 4 | Per-group combined interrupt level |
| exc_o | output | 1 | Combined exception level |
| sw_evt_valid_o | output | 1 | One-cycle software event request |
| sw_evt_data_o | output | 32 | Value carried by the software event request |

## Verification
A flag that is lost or left stuck shows up at once in the read-back of the flag bank and in the masked views. It also shows on the interrupt or exception line on the very edge after the event, set or clear that should have changed it. A bad mask bit shows only when a flag is pending under it, so the tests make a bit pending first and then move the mask around it. A wrong priority between clear and a same-cycle event shows as a flag reading 0 one edge after the collision.

// File: rtl/evc_pkg.sv
package evc_pkg;

    typedef enum logic [2:0] {
        BK_FLAG   = 3'd0,
        BK_SET    = 3'd1,
        BK_CLR    = 3'd2,
        BK_EMASK  = 3'd3,
        BK_EVIEW  = 3'd4,
        BK_XMASK  = 3'd5,
        BK_XVIEW  = 3'd6,
        BK_ASSERT = 3'd7
    } bank_e;

endpackage

// File: rtl/evc_group.sv
module evc_group #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         em_we,
    input  logic         xm_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] flag_o,
    output logic [W-1:0] emask_o,
    output logic [W-1:0] xmask_o,
    output logic [W-1:0] eview_o,
    output logic [W-1:0] xview_o,
    output logic         irq_o,
    output logic         exc_o
);

    typedef struct packed {
        logic [W-1:0] flag;
        logic [W-1:0] emask;
        logic [W-1:0] xmask;
        logic         irq;
        logic         exc;
    } grp_st_t;

    grp_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) st_d.flag = st_d.flag & ~wdata;
        if (set_we) st_d.flag = st_d.flag | wdata;
        st_d.flag = st_d.flag | evt_i;
        if (em_we) st_d.emask = wdata;
        if (xm_we) st_d.xmask = wdata;
        st_d.irq = |(st_d.flag & ~st_d.emask);
        st_d.exc = |(st_d.flag & ~st_d.xmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag  <= '0;
            st_q.emask <= '1;
            st_q.xmask <= '1;
            st_q.irq   <= 1'b0;
            st_q.exc   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o  = st_q.flag;
    assign emask_o = st_q.emask;
    assign xmask_o = st_q.xmask;
    assign eview_o = st_q.flag & ~st_q.emask;
    assign xview_o = st_q.flag & ~st_q.xmask;
    assign irq_o   = st_q.irq;
    assign exc_o   = st_q.exc;

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flag & $past(evt_i)) == $past(evt_i))); // R1

    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && evt_i == '0) |=> ((st_q.flag & $past(wdata)) == '0)); // R3

    AST_SET_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((st_q.flag & $past(wdata)) == $past(wdata))); // R2

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|eview_o)); // R7

    AST_EXC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o == (|xview_o)); // R8

endmodule

// File: rtl/evc_regif.sv
module evc_regif
    import evc_pkg::*;
#(
    parameter int G      = 4,
    parameter int W      = 32,
    parameter int GSEL_W = 3,
    localparam int AW    = 3 + GSEL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_sel,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [W-1:0]   bus_wdata,
    input  logic [G*W-1:0] flag_i,
    input  logic [G*W-1:0] emask_i,
    input  logic [G*W-1:0] xmask_i,
    input  logic [G*W-1:0] eview_i,
    input  logic [G*W-1:0] xview_i,
    output logic [G-1:0]   set_we_o,
    output logic [G-1:0]   clr_we_o,
    output logic [G-1:0]   em_we_o,
    output logic [G-1:0]   xm_we_o,
    output logic [W-1:0]   rdata_o,
    output logic           asrt_valid_o,
    output logic [W-1:0]   asrt_data_o
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } asrt_st_t;

    asrt_st_t    asrt_d, asrt_q;
    bank_e       bank;
    logic [GSEL_W-1:0] grp;
    logic        wr;
    logic        assert_we;

    assign bank = bank_e'(bus_addr[AW-1:GSEL_W]);
    assign grp  = bus_addr[GSEL_W-1:0];
    assign wr   = bus_sel & bus_we;
    assign assert_we = wr && (bank == BK_ASSERT) && (grp == '0);

    always_comb begin
        set_we_o = '0;
        clr_we_o = '0;
        em_we_o  = '0;
        xm_we_o  = '0;
        rdata_o  = '0;
        for (int g = 0; g < G; g++) begin
            if (grp == GSEL_W'(g)) begin
                set_we_o[g] = wr && (bank == BK_SET);
                clr_we_o[g] = wr && (bank == BK_CLR);
                em_we_o[g]  = wr && (bank == BK_EMASK);
                xm_we_o[g]  = wr && (bank == BK_XMASK);
                case (bank)
                    BK_FLAG:  rdata_o = flag_i[g*W +: W];
                    BK_EMASK: rdata_o = emask_i[g*W +: W];
                    BK_EVIEW: rdata_o = eview_i[g*W +: W];
                    BK_XMASK: rdata_o = xmask_i[g*W +: W];
                    BK_XVIEW: rdata_o = xview_i[g*W +: W];
                    default:  rdata_o = '0;
                endcase
            end
        end
    end

    always_comb begin
        asrt_d       = asrt_q;
        asrt_d.valid = assert_we;
        if (assert_we) asrt_d.data = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asrt_q <= '0;
        end else begin
            asrt_q <= asrt_d;
        end
    end

    assign asrt_valid_o = asrt_q.valid;
    assign asrt_data_o  = asrt_q.data;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_we_o, clr_we_o, em_we_o, xm_we_o, assert_we})); // R10

    AST_ASRT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        assert_we |=> (asrt_valid_o && asrt_data_o == $past(bus_wdata))); // R9

    AST_ASRT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !assert_we |=> !asrt_valid_o); // R9

endmodule

// File: rtl/evt_combiner.sv
module evt_combiner #(
    parameter int GRP_N  = 4,
    parameter int GRP_W  = 32,
    parameter int GSEL_W = 3,
    localparam int AW    = 3 + GSEL_W,
    localparam int EVT_N = GRP_N * GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] evt_i,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [GRP_W-1:0] bus_wdata,
    output logic [GRP_W-1:0] bus_rdata,
    output logic [GRP_N-1:0] grp_irq_o,
    output logic             exc_o,
    output logic             sw_evt_valid_o,
    output logic [GRP_W-1:0] sw_evt_data_o
);

    logic [EVT_N-1:0] flag_w, emask_w, xmask_w, eview_w, xview_w;
    logic [GRP_N-1:0] set_we, clr_we, em_we, xm_we, exc_w;

    evc_regif #(.G(GRP_N), .W(GRP_W), .GSEL_W(GSEL_W)) u_regif (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .flag_i       (flag_w),
        .emask_i      (emask_w),
        .xmask_i      (xmask_w),
        .eview_i      (eview_w),
        .xview_i      (xview_w),
        .set_we_o     (set_we),
        .clr_we_o     (clr_we),
        .em_we_o      (em_we),
        .xm_we_o      (xm_we),
        .rdata_o      (bus_rdata),
        .asrt_valid_o (sw_evt_valid_o),
        .asrt_data_o  (sw_evt_data_o)
    );

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        evc_group #(.W(GRP_W)) u_grp (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_i[g*GRP_W +: GRP_W]),
            .set_we  (set_we[g]),
            .clr_we  (clr_we[g]),
            .em_we   (em_we[g]),
            .xm_we   (xm_we[g]),
            .wdata   (bus_wdata),
            .flag_o  (flag_w[g*GRP_W +: GRP_W]),
            .emask_o (emask_w[g*GRP_W +: GRP_W]),
            .xmask_o (xmask_w[g*GRP_W +: GRP_W]),
            .eview_o (eview_w[g*GRP_W +: GRP_W]),
            .xview_o (xview_w[g*GRP_W +: GRP_W]),
            .irq_o   (grp_irq_o[g]),
            .exc_o   (exc_w[g])
        );
    end

    assign exc_o = |exc_w;

    AST_EXC_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o == (|xview_w)); // R8

endmodule

// File: tb/tb_evt_combiner.sv
`timescale 1ns/1ps
module tb_evt_combiner;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] evt_i = '0;
    logic         bus_sel = 1'b0;
    logic         bus_we = 1'b0;
    logic [5:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [3:0]   grp_irq_o;
    logic         exc_o;
    logic         sw_evt_valid_o;
    logic [31:0]  sw_evt_data_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    evt_combiner dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .grp_irq_o(grp_irq_o), .exc_o(exc_o),
        .sw_evt_valid_o(sw_evt_valid_o), .sw_evt_data_o(sw_evt_data_o)
    );

    // bank codes (R10)
    localparam logic [2:0] B_FLAG = 3'd0, B_SET = 3'd1, B_CLR = 3'd2,
        B_EMASK = 3'd3, B_EVIEW = 3'd4, B_XMASK = 3'd5, B_XVIEW = 3'd6, B_ASRT = 3'd7;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] bank, input logic [2:0] grp, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {bank, grp}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] bank, input logic [2:0] grp, output logic [31:0] d);
        bus_addr = {bank, grp};
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pulse(input int n);
        @(negedge clk);
        evt_i = '0; evt_i[n] = 1'b1;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int g = 0; g < 4; g++) begin
            bus_read(B_FLAG, 3'(g), v);  check("R4 flag after reset", v, 32'h0);
            bus_read(B_EMASK, 3'(g), v); check("R4 irq mask after reset", v, 32'hFFFF_FFFF);
            bus_read(B_XMASK, 3'(g), v); check("R4 exc mask after reset", v, 32'hFFFF_FFFF);
        end
        check("R4 irq low", {28'h0, grp_irq_o}, 32'h0);
        check("R4 exc low", {31'h0, exc_o}, 32'h0);
        check("R4 assert low", {31'h0, sw_evt_valid_o}, 32'h0);
    endtask

    task automatic t_event;
        logic [31:0] v;
        pulse(37);
        pulse(127);
        bus_read(B_FLAG, 3'd1, v); check("R1 event 37 in group 1 bit 5", v, 32'h0000_0020);
        bus_read(B_FLAG, 3'd3, v); check("R1 event 127 in group 3 bit 31", v, 32'h8000_0000);
        bus_read(B_FLAG, 3'd0, v); check("R1 group 0 untouched", v, 32'h0);
        check("R5 masked flags raise no irq", {28'h0, grp_irq_o}, 32'h0);
        bus_read(B_EVIEW, 3'd1, v); check("R6 view fully masked", v, 32'h0);
    endtask

    task automatic t_mask_irq;
        logic [31:0] v;
        bus_write(B_EMASK, 3'd1, ~32'h20);
        check("R7 irq1 same edge as unmask", {28'h0, grp_irq_o}, 32'h2);
        bus_read(B_EMASK, 3'd1, v); check("R5 mask readback", v, ~32'h20);
        bus_read(B_EVIEW, 3'd1, v); check("R6 irq view", v, 32'h20);
        bus_write(B_EMASK, 3'd1, 32'hFFFF_FFFF);
        check("R5 remask blocks irq", {28'h0, grp_irq_o}, 32'h0);
        bus_write(B_EMASK, 3'd1, 32'h0);
        bus_write(B_CLR, 3'd1, 32'h20);
        check("R7 irq1 drops with clear", {28'h0, grp_irq_o}, 32'h0);
        bus_read(B_FLAG, 3'd1, v); check("R3 cleared flag", v, 32'h0);
    endtask

    task automatic t_set;
        logic [31:0] v;
        bus_write(B_SET, 3'd2, 32'h8000_0001);
        bus_read(B_FLAG, 3'd2, v); check("R2 set bits", v, 32'h8000_0001);
        bus_write(B_SET, 3'd2, 32'h0);
        bus_read(B_FLAG, 3'd2, v); check("R2 zero write no change", v, 32'h8000_0001);
        bus_write(B_CLR, 3'd2, 32'h0);
        bus_read(B_FLAG, 3'd2, v); check("R3 zero clear no change", v, 32'h8000_0001);
        bus_write(B_CLR, 3'd2, 32'h0000_0001);
        bus_read(B_FLAG, 3'd2, v); check("R3 clear one bit", v, 32'h8000_0000);
    endtask

    task automatic t_clear_race;
        logic [31:0] v;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = {B_CLR, 3'd0}; bus_wdata = 32'h8;
        evt_i = '0; evt_i[3] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; evt_i = '0;
        bus_read(B_FLAG, 3'd0, v); check("R3 event beats clear", v, 32'h8);
        bus_write(B_CLR, 3'd0, 32'h8);
        bus_read(B_FLAG, 3'd0, v); check("R3 later clear", v, 32'h0);
    endtask

    task automatic t_exc;
        logic [31:0] v;
        check("R8 exc low while masked", {31'h0, exc_o}, 32'h0);
        bus_write(B_XMASK, 3'd3, 32'h7FFF_FFFF);
        check("R8 exc high", {31'h0, exc_o}, 32'h1);
        bus_read(B_XVIEW, 3'd3, v); check("R6 exc view", v, 32'h8000_0000);
        bus_read(B_XMASK, 3'd3, v); check("R5 exc mask readback", v, 32'h7FFF_FFFF);
        check("R5 exc plane leaves irq alone", {28'h0, grp_irq_o}, 32'h0);
        bus_write(B_CLR, 3'd3, 32'h8000_0000);
        check("R8 exc low after clear", {31'h0, exc_o}, 32'h0);
    endtask

    task automatic t_assert;
        bus_write(B_ASRT, 3'd0, 32'h0000_00A5);
        check("R9 valid pulse", {31'h0, sw_evt_valid_o}, 32'h1);
        check("R9 data", sw_evt_data_o, 32'h0000_00A5);
        @(negedge clk);
        check("R9 single cycle", {31'h0, sw_evt_valid_o}, 32'h0);
    endtask

    task automatic t_access;
        logic [31:0] v;
        bus_write(B_FLAG, 3'd0, 32'hFFFF_FFFF);
        bus_read(B_FLAG, 3'd0, v); check("R10 flag bank write ignored", v, 32'h0);
        bus_write(B_EVIEW, 3'd0, 32'hFFFF_FFFF);
        bus_write(B_XVIEW, 3'd0, 32'hFFFF_FFFF);
        bus_read(B_FLAG, 3'd0, v); check("R10 view write ignored", v, 32'h0);
        bus_read(B_EMASK, 3'd0, v); check("R10 view write leaves mask", v, 32'hFFFF_FFFF);
        bus_write(B_SET, 3'd0, 32'h10);
        bus_read(B_SET, 3'd0, v); check("R10 set bank reads zero", v, 32'h0);
        bus_read(B_CLR, 3'd0, v); check("R10 clear bank reads zero", v, 32'h0);
        bus_read(B_ASRT, 3'd0, v); check("R10 assert bank reads zero", v, 32'h0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event();
        t_mask_irq();
        t_set();
        t_clear_race();
        t_exc();
        t_assert();
        t_access();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule